// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block chooses which of a set of interrupt lines should be serviced next. Each line carries a priority value held in a byte-wide register, of which only the upper `PRIO_BITS` bits are stored. A lower number means a more urgent line. Among all lines that are both pending and enabled, the arbiter picks the one with the smallest priority value. When two lines have the same value, the one with the lower index wins.

A 3-bit group setting `G` splits every priority byte into two fields. Bits [7:G+1] form the preempt field and bits [G:0] form the subpriority field. Selection always orders lines by the whole value. The group setting controls two things: which bits make up the exported preempt level, and the comparison against the current execution priority. A preempt request is raised only when the winner's preempt level is strictly below the current execution priority masked in the same way. With `G` = 7 the preempt field is empty, so no preemption can occur.

The winner, its preempt level, a valid flag and the preempt request are all registered, one clock after the inputs they depend on. A single configuration port writes and reads the priority registers and the group setting.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, `win_valid` and `preempt_req` are 0, every priority register reads 0, and the group setting reads 0.
- R2: A write with `cfg_is_grp`=0 stores the top `PRIO_BITS` bits of `cfg_wdata` for line `cfg_addr`. A read of that line returns those bits with the low 8-`PRIO_BITS` bits zero, so writing 0xFF reads back `PRIO_BITS` ones followed by zeros.
- R3: A write with `cfg_is_grp`=1 stores `cfg_wdata[2:0]` as the group setting. A read with `cfg_is_grp`=1 returns it in `cfg_rdata[2:0]` with bits [7:3] zero.
- R4: `win_valid` is 1 exactly one clock after a cycle in which at least one line has both its `pend` and `en` bits set.
- R5: `win_id` is the pending and enabled line with the smallest priority value. Equal values resolve to the lowest index, whatever the group setting.
- R6: `win_level` equals the winner's priority byte with bits [G:0] forced to zero.
- R7: `preempt_req` is 1 only when `win_valid` is 1 and `win_level` is strictly below `cur_prio` with bits [G:0] forced to zero. An equal or larger preempt level does not raise it.
- R8: While the group setting is 7, `preempt_req` stays 0.
- R9: A priority write to an address of `NUM_IRQ` or more changes no register, and a read of such an address returns 0.
- R10: A line whose `pend` or `en` bit is 0 never wins, whatever its priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend | input | NUM_IRQ | Pending bit per line |
| en | input | NUM_IRQ | Enable bit per line |
| cur_prio | input | 8 | Current execution priority |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_grp | input | 1 | 1 selects the group setting, 0 selects a priority register |
| cfg_addr | input | ADDR_W | Line index for priority access |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data (combinational) |
| win_valid | output | 1 | A winner exists |
| win_id | output | ID_W | Index of the winning line |
| win_level | output | 8 | Winner preempt level, subpriority bits zero |
| preempt_req | output | 1 | Winner beats the current execution priority |

## Verification
Winner outputs and the preempt request come from one register stage. The bench therefore drives `pend`, `en` and `cur_prio` on a falling edge, lets one rising edge pass, and compares at the next falling edge. Configuration reads are combinational. They are checked a short delay after the address settles, and a write is checked on the falling edge after the rising edge that stores it. Random patterns, with occasional priority and group rewrites, are mixed with directed ties, equal-level non-preemption, the empty-preempt-field group and out-of-range writes.

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 8,
  localparam int ID_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int PAD      = 8 - PRIO_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [7:0]         cur_prio,
  input  logic               cfg_we,
  input  logic               cfg_is_grp,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  output logic               win_valid,
  output logic [ID_W-1:0]    win_id,
  output logic [7:0]         win_level,
  output logic               preempt_req
);

  logic [PRIO_BITS-1:0] prio_q [NUM_IRQ];
  logic [7:0]           full   [NUM_IRQ];
  logic [2:0]           grp_q;
  logic [7:0]           pmask;
  logic [7:0]           rd_prio;
  logic                 found;
  logic [ID_W-1:0]      best_id;
  logic [7:0]           best_p;
  logic [7:0]           lvl;
  logic                 armed;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_widen
    assign full[i] = 8'(prio_q[i]) << PAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_is_grp) grp_q <= cfg_wdata[2:0];
      else
        for (int i = 0; i < NUM_IRQ; i++)
          if (cfg_addr == ADDR_W'(i)) prio_q[i] <= cfg_wdata[7 -: PRIO_BITS];
    end
  end

  always_comb begin
    rd_prio = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (cfg_addr == ADDR_W'(i)) rd_prio = full[i];
  end

  assign cfg_rdata = cfg_is_grp ? {5'b0, grp_q} : rd_prio;

  always_comb begin
    for (int b = 0; b < 8; b++) pmask[b] = (b > int'(grp_q));
  end

  always_comb begin
    found   = 1'b0;
    best_id = '0;
    best_p  = 8'hFF;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend[i] && en[i] && (!found || full[i] < best_p)) begin
        found   = 1'b1;
        best_id = ID_W'(i);
        best_p  = full[i];
      end
    end
  end

  assign lvl = best_p & pmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid   <= 1'b0;
      win_id      <= '0;
      win_level   <= '0;
      preempt_req <= 1'b0;
      armed       <= 1'b0;
    end else begin
      win_valid   <= found;
      win_id      <= best_id;
      win_level   <= found ? lvl : 8'h00;
      preempt_req <= found && (lvl < (cur_prio & pmask));
      armed       <= 1'b1;
    end
  end

  p_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (win_valid == $past(|(pend & en))));

  p_winner_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && win_valid) |-> ((($past(pend & en)) >> win_id) & NUM_IRQ'(1)) != '0);

  p_pre_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> win_valid);

  p_no_pre_grp7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && grp_q == 3'd7 && $past(grp_q) == 3'd7) |-> !preempt_req);

  p_level_sub_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $stable(grp_q)) |-> ((win_level & ~pmask) == 8'h00));

  if (PAD > 0) begin : g_pad_chk
    p_rd_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_is_grp |-> (cfg_rdata[PAD-1:0] == '0));
  end

  p_grp_rd_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_is_grp |-> (cfg_rdata[7:3] == 5'b0));

endmodule

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;
  localparam int N = 8;
  localparam int PB = 4;
  localparam int AW = 8;
  localparam int IW = 3;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] IMASK = 8'hFF << (8 - PB);

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pend = '0, en = '0;
  logic [7:0] cur_prio = '0;
  logic cfg_we = 0, cfg_is_grp = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic win_valid, preempt_req;
  logic [IW-1:0] win_id;
  logic [7:0] win_level;

  int checks = 0, errors = 0;
  logic [7:0] bm_prio [N];
  logic [2:0] bm_grp;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_arbiter #(.NUM_IRQ(N), .PRIO_BITS(PB), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .pend(pend), .en(en), .cur_prio(cur_prio),
    .cfg_we(cfg_we), .cfg_is_grp(cfg_is_grp), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win_valid(win_valid),
    .win_id(win_id), .win_level(win_level), .preempt_req(preempt_req));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gmask(input logic [2:0] g);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = (b > int'(g));
    return m;
  endfunction

  task automatic wr_prio(input int a, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_is_grp = 0; cfg_addr = AW'(a); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    if (a < N) bm_prio[a] = v & IMASK;
  endtask

  task automatic wr_grp(input logic [2:0] g);
    @(negedge clk);
    cfg_we = 1; cfg_is_grp = 1; cfg_wdata = {5'b0, g};
    @(negedge clk);
    cfg_we = 0; cfg_is_grp = 0;
    bm_grp = g;
  endtask

  task automatic apply_check(input logic [N-1:0] p, input logic [N-1:0] e,
                             input logic [7:0] c, input string tag);
    bit f = 0;
    int id = 0;
    logic [7:0] bp = 8'hFF, lv;
    bit pr;
    @(negedge clk);
    pend = p; en = e; cur_prio = c;
    for (int i = 0; i < N; i++)
      if (p[i] && e[i] && (!f || bm_prio[i] < bp)) begin f = 1; id = i; bp = bm_prio[i]; end
    lv = bp & gmask(bm_grp);
    pr = f && (lv < (c & gmask(bm_grp)));
    @(negedge clk);
    chk(win_valid == f, {tag, " R4 valid"}, win_valid, f);
    if (f) begin
      chk(int'(win_id) == id, {tag, " R5/R10 id"}, win_id, id);
      chk(win_level == lv, {tag, " R6 level"}, win_level, lv);
    end
    chk(preempt_req == pr, {tag, " R7 preempt"}, preempt_req, pr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) bm_prio[i] = '0;
    bm_grp = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(win_valid == 0 && preempt_req == 0, "R1 outputs", {win_valid, preempt_req}, 0);
    for (int i = 0; i < N; i++) begin
      cfg_addr = AW'(i); #1;
      chk(cfg_rdata == 0, "R1 prio reset", cfg_rdata, 0);
    end
    cfg_is_grp = 1; #1;
    chk(cfg_rdata == 0, "R1 group reset", cfg_rdata, 0);
    cfg_is_grp = 0;

    wr_prio(2, 8'hFF);
    cfg_addr = 2; #1;
    chk(cfg_rdata == IMASK, "R2 0xFF readback", cfg_rdata, IMASK);
    wr_prio(3, 8'h5A);
    cfg_addr = 3; #1;
    chk(cfg_rdata == (8'h5A & IMASK), "R2 readback", cfg_rdata, 8'h5A & IMASK);

    wr_grp(3'd5);
    cfg_is_grp = 1; #1;
    chk(cfg_rdata == 8'h05, "R3 group readback", cfg_rdata, 8'h05);
    cfg_is_grp = 0;

    wr_prio(200, 8'h30);
    cfg_addr = 200; #1;
    chk(cfg_rdata == 0, "R9 oob read", cfg_rdata, 0);
    for (int i = 0; i < N; i++) begin
      cfg_addr = AW'(i); #1;
      chk(cfg_rdata == bm_prio[i], "R9 oob write ignored", cfg_rdata, bm_prio[i]);
    end

    for (int i = 0; i < N; i++) wr_prio(i, 8'h40);
    wr_grp(3'd3);
    apply_check(8'b1010_0000, 8'hFF, 8'hFF, "tie R5");
    chk(win_id == 5, "R5 lowest index tie", win_id, 5);
    apply_check('0, 8'hFF, 8'hFF, "none R4");
    wr_prio(0, 8'h00);
    apply_check(8'hFF, 8'hFE, 8'hFF, "disabled R10");
    apply_check(8'hFE, 8'hFF, 8'hFF, "notpend R10");
    wr_prio(6, 8'h50);
    wr_prio(7, 8'h40);
    apply_check(8'b1100_0000, 8'hFF, 8'h40, "equal-level R7");
    chk(preempt_req == 0, "R7 equal no preempt", preempt_req, 0);
    apply_check(8'b1100_0000, 8'hFF, 8'h50, "strict R7");
    wr_grp(3'd7);
    apply_check(8'hFF, 8'hFF, 8'hFF, "grp7 R8");
    chk(preempt_req == 0, "R8 no preempt", preempt_req, 0);

    for (int it = 0; it < 400; it++) begin
      if (it % 6 == 0) wr_prio(int'($urandom % (N + 2)), 8'($urandom));
      if (it % 40 == 0) wr_grp(3'($urandom));
      apply_check(N'($urandom), N'($urandom), 8'($urandom), "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule